// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps an asynchronous DRAM alive by issuing refresh cycles in which the column strobe falls before the row strobe. In that ordering the device uses its own internal row counter, so the memory controller does not have to track a refresh address. The block drives the row strobe, the column strobe and the write enable only while it holds the bus. The access controller takes those pins back at all other times.

After reset the scheduler first waits out a power-up pause. It then runs a burst of eight refresh cycles with no handshake, and after that it raises `init_done`. From then on an interval timer adds one owed refresh per period to a saturating backlog, and `ref_req` stays high while refreshes are owed. The access controller answers with `ref_gnt` once the row is closed. Refreshes may be postponed up to a limit of eight. At that limit `ref_urgent` rises, and the controller must grant at its next idle point. Every count of cycles is a parameter. This covers the pause, the interval and each strobe phase.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, `ras_n`, `cas_n` and `we_n` are 1, and `ref_req`, `ref_urgent`, `bus_own` and `init_done` are 0.
- R2: No strobe goes low during the first POWERUP_CYC clock cycles after reset is released.
- R3: After the pause, exactly INIT_REFS (8) refresh cycles run with no grant needed. `init_done` then rises and stays high. `ref_req` stays low until `init_done` is high.
- R4: In every refresh cycle `cas_n` goes low while `ras_n` is high. It stays low for exactly T_CSR cycles before `ras_n` falls.
- R5: After `ras_n` falls, `cas_n` stays low for exactly T_CHR cycles. It then returns high while `ras_n` is still low.
- R6: `ras_n` stays low for exactly T_RAS cycles. From its rise until the next fall of `cas_n`, both strobes stay high for at least T_RP+T_RPC cycles.
- R7: `we_n` is 1 in every cycle, including every refresh cycle.
- R8: `bus_own` is 1 in every cycle in which `ras_n` or `cas_n` is 0. `ref_req` is 0 while `bus_own` is 1.
- R9: After `init_done`, one refresh becomes owed every INTERVAL_CYC cycles. When grant is always given, N intervals produce N refresh cycles.
- R10: After `init_done`, a refresh cycle starts only in a cycle where `ref_req` and `ref_gnt` are both 1.
- R11: The count of owed refreshes saturates at BACKLOG_MAX (8), and `ref_urgent` is 1 exactly while it is at that limit. After eight or more missed intervals, granting yields exactly 8 refresh cycles. After those, `ref_req` and `ref_urgent` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Access controller grants the bus; row is closed |
| ref_req | output | 1 | One or more refreshes are owed |
| ref_urgent | output | 1 | Backlog at its limit; grant at next idle point |
| bus_own | output | 1 | Scheduler is driving the DRAM control pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| init_done | output | 1 | Power-up sequence complete |

## Verification
The bench first runs the ungranted power-up burst. The only checks there are the pause length and the count of eight cycles. Next, grant is held off for twelve intervals. This tells a saturating backlog apart from one that wraps or keeps growing, because exactly eight cycles must follow the grant. It also shows that nothing starts without a grant. Finally, grant is held high for twenty intervals, which measures the steady refresh rate. Every cycle in all three patterns has its CAS setup, CAS hold, RAS width and precharge gap measured against the parameters.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_CSR,
    ST_RASLO,
    ST_RP
  } strobe_st_e;
endpackage

// File: rtl/rfsh_strobe.sv
module rfsh_strobe
  import rfsh_pkg::*;
#(
  parameter int T_RPC = 3,
  parameter int T_CSR = 2,
  parameter int T_CHR = 3,
  parameter int T_RAS = 13,
  parameter int T_RP  = 8
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_no,
  output logic cas_no
);
  localparam int M1   = (T_RPC > T_CSR) ? T_RPC : T_CSR;
  localparam int M2   = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int MAXP = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXP + 1);
  localparam logic [CW-1:0] LD_RPC = CW'(T_RPC - 1);
  localparam logic [CW-1:0] LD_CSR = CW'(T_CSR - 1);
  localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] CAS_HI = CW'(T_RAS - T_CHR);

  strobe_st_e      st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            last;

  assign last = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE: if (start_i) begin st_d = ST_PRE; cnt_d = LD_RPC; end
      ST_PRE:  if (last) begin st_d = ST_CSR; cnt_d = LD_CSR; end
               else cnt_d = cnt_q - 1'b1;
      ST_CSR:  if (last) begin st_d = ST_RASLO; cnt_d = LD_RAS; end
               else cnt_d = cnt_q - 1'b1;
      ST_RASLO: if (last) begin st_d = ST_RP; cnt_d = LD_RP; end
               else cnt_d = cnt_q - 1'b1;
      ST_RP:   if (last) st_d = ST_IDLE;
               else cnt_d = cnt_q - 1'b1;
      default: begin st_d = ST_IDLE; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_RP) && last;
  assign ras_no = !(st_q == ST_RASLO);
  assign cas_no = !((st_q == ST_CSR) || ((st_q == ST_RASLO) && (cnt_q >= CAS_HI)));

  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(ras_no) |-> (!cas_no && $past(!cas_no))); // R4
  AST_CAS_RISES_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(cas_no) |-> !ras_no); // R5
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    start_i |-> !busy_o); // R8
endmodule

// File: rtl/rfsh_init.sv
module rfsh_init #(
  parameter int POWERUP_CYC = 50000,
  parameter int INIT_REFS   = 8
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic busy_i,
  output logic kick_o,
  output logic init_done_o
);
  localparam int PW = $clog2(POWERUP_CYC);
  localparam int IW = $clog2(INIT_REFS + 1);
  localparam logic [PW-1:0] P_LAST = PW'(POWERUP_CYC - 1);
  localparam logic [IW-1:0] N_REFS = IW'(INIT_REFS);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          pdone_q, pdone_d;
  logic [IW-1:0] issued_q, issued_d;
  logic          done_q, done_d;
  logic          pcnt_en, issued_en;

  assign kick_o    = pdone_q && !done_q && !busy_i && (issued_q != N_REFS);
  assign pcnt_en   = !pdone_q;
  assign issued_en = kick_o;

  always_comb begin
    pcnt_d   = pcnt_q + 1'b1;
    pdone_d  = pdone_q || (pcnt_q == P_LAST);
    issued_d = issued_q + 1'b1;
    done_d   = done_q || (pdone_q && (issued_q == N_REFS) && !busy_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q   <= '0;
      pdone_q  <= 1'b0;
      issued_q <= '0;
      done_q   <= 1'b0;
    end else begin
      if (pcnt_en) begin
        pcnt_q  <= pcnt_d;
        pdone_q <= pdone_d;
      end
      if (issued_en) issued_q <= issued_d;
      done_q <= done_d;
    end
  end

  assign init_done_o = done_q;

  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    init_done_o |=> init_done_o); // R3
  AST_NO_KICK_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_ni)
    !pdone_q |-> !kick_o && !busy_i); // R2
endmodule

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
  parameter int INTERVAL_CYC = 3900
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int TW = $clog2(INTERVAL_CYC);
  localparam logic [TW-1:0] T_LAST = TW'(INTERVAL_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap   = (cnt_q == T_LAST);
  assign tick_o = run_i && wrap;

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int BACKLOG_MAX = 8
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic pending_o,
  output logic urgent_o
);
  localparam int BW = $clog2(BACKLOG_MAX + 1);
  localparam logic [BW-1:0] B_MAX = BW'(BACKLOG_MAX);

  logic [BW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = inc_i ^ dec_i;

  always_comb begin
    if (inc_i) cnt_d = (cnt_q == B_MAX) ? cnt_q : cnt_q + 1'b1;
    else       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pending_o = (cnt_q != '0);
  assign urgent_o  = (cnt_q == B_MAX);

  AST_BACKLOG_LIMIT: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= B_MAX); // R11
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (urgent_o && inc_i && !dec_i) |=> urgent_o); // R11
  AST_DEC_ONLY_OWED: assert property (@(posedge clk) disable iff (!rst_ni)
    dec_i |-> pending_o); // R10
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int POWERUP_CYC  = 50000,
  parameter int INIT_REFS    = 8,
  parameter int INTERVAL_CYC = 3900,
  parameter int BACKLOG_MAX  = 8,
  parameter int T_RPC        = 3,
  parameter int T_CSR        = 2,
  parameter int T_CHR        = 3,
  parameter int T_RAS        = 13,
  parameter int T_RP         = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_urgent,
  output logic bus_own,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic init_done
);
  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       busy, done, kick, tick, pending, take, start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  rfsh_init #(.POWERUP_CYC(POWERUP_CYC), .INIT_REFS(INIT_REFS)) u_init (
    .clk(clk), .rst_ni(rst_int_n), .busy_i(busy),
    .kick_o(kick), .init_done_o(init_done)
  );

  rfsh_interval #(.INTERVAL_CYC(INTERVAL_CYC)) u_interval (
    .clk(clk), .rst_ni(rst_int_n), .run_i(init_done), .tick_o(tick)
  );

  rfsh_backlog #(.BACKLOG_MAX(BACKLOG_MAX)) u_backlog (
    .clk(clk), .rst_ni(rst_int_n), .inc_i(tick), .dec_i(take),
    .pending_o(pending), .urgent_o(ref_urgent)
  );

  assign ref_req = init_done && pending && !busy;
  assign take    = ref_req && ref_gnt;
  assign start   = kick || take;

  rfsh_strobe #(
    .T_RPC(T_RPC), .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)
  ) u_strobe (
    .clk(clk), .rst_ni(rst_int_n), .start_i(start),
    .busy_o(busy), .done_o(done), .ras_no(ras_n), .cas_no(cas_n)
  );

  assign bus_own = busy;
  assign we_n    = 1'b1;

  AST_REQ_QUIET_WHILE_OWN: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_own |-> !ref_req); // R8
  AST_STROBES_UNDER_OWN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ras_n || !cas_n) |-> bus_own); // R8
  AST_NO_START_UNGRANTED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (init_done && !bus_own && !(ref_req && ref_gnt)) |=> !bus_own); // R10
  AST_DONE_ENDS_OWN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !kick) |=> !bus_own || ref_req); // R8
endmodule

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
  localparam int POWERUP = 400;
  localparam int NREF    = 8;
  localparam int IVL     = 300;
  localparam int BMAX    = 8;
  localparam int TRPC = 3, TCSR = 2, TCHR = 3, TRAS = 13, TRP = 8;

  typedef struct { int csr; int chr; int ras; } exp_t;

  logic clk, rst_n, ref_gnt;
  logic ref_req, ref_urgent, bus_own, ras_n, cas_n, we_n, init_done;

  int checks, fails;
  int cyc, rel_cyc, first_cas, completed;
  exp_t q[$];
  int csr_c, chr_c, ras_c, gap_c;
  logic ras_seen, have_prev, prev_ras, prev_cas, we_bad, own_bad, rst_seen_rel;

  refresh_sched #(
    .POWERUP_CYC(POWERUP), .INIT_REFS(NREF), .INTERVAL_CYC(IVL), .BACKLOG_MAX(BMAX),
    .T_RPC(TRPC), .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .init_done(init_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_refs(input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.csr = TCSR; e.chr = TCHR; e.ras = TRAS;
      q.push_back(e);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // monitor: measures each refresh cycle and pops the scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      csr_c = 0; chr_c = 0; ras_c = 0; gap_c = 0;
      ras_seen = 0; have_prev = 0; prev_ras = 1; prev_cas = 1;
    end else begin
      if (we_n !== 1'b1) we_bad = 1;
      if ((!ras_n || !cas_n) && !bus_own) own_bad = 1;
      if (prev_cas && !cas_n) begin
        if (first_cas < 0) first_cas = cyc;
        if (have_prev) check(gap_c >= TRP + TRPC, "R6 precharge gap", gap_c, TRP + TRPC);
      end
      if (!cas_n && ras_n && !ras_seen) csr_c++;
      if (!ras_n) begin
        ras_c++; ras_seen = 1;
        if (!cas_n) chr_c++;
      end
      if (ras_n && !prev_ras) begin
        completed++;
        if (q.size() == 0) begin
          check(0, "R10 unexpected refresh", completed, completed - 1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(csr_c == e.csr, "R4 CAS setup", csr_c, e.csr);
          check(chr_c == e.chr, "R5 CAS hold", chr_c, e.chr);
          check(ras_c == e.ras, "R6 RAS width", ras_c, e.ras);
        end
        csr_c = 0; chr_c = 0; ras_c = 0; ras_seen = 0; have_prev = 1; gap_c = 1;
      end else if (ras_n && cas_n) begin
        gap_c++;
      end
      prev_ras = ras_n; prev_cas = cas_n;
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int t0;
    checks = 0; fails = 0; cyc = 0; completed = 0; first_cas = -1;
    we_bad = 0; own_bad = 0;
    rst_n = 1'b0; ref_gnt = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ras_n && cas_n && we_n, "R1 strobes high", {ras_n, cas_n, we_n}, 7);
    check(!ref_req && !ref_urgent && !bus_own && !init_done, "R1 flags low",
          {ref_req, ref_urgent, bus_own, init_done}, 0);
    rst_n = 1'b1;
    rel_cyc = cyc;
    expect_refs(NREF);
    @(negedge clk);
    check(ras_n && cas_n && !init_done, "R1 after release", {ras_n, cas_n, init_done}, 6);
    while (!init_done) begin
      check(!ref_req, "R3 no request before ready", ref_req, 0);
      @(negedge clk);
    end
    t0 = cyc;
    check(first_cas - rel_cyc >= POWERUP, "R2 power-up pause", first_cas - rel_cyc, POWERUP);
    check(completed == NREF, "R3 init burst count", completed, NREF);
    // hold off grant for twelve intervals
    wait_until(t0 + 12 * IVL + 20);
    check(completed == NREF, "R10 no refresh without grant", completed, NREF);
    check(ref_urgent == 1'b1, "R11 urgent at limit", ref_urgent, 1);
    check(ref_req == 1'b1, "R9 request pending", ref_req, 1);
    expect_refs(BMAX);
    ref_gnt = 1'b1;
    wait_until(t0 + 12 * IVL + 270);
    check(completed == NREF + BMAX, "R11 drained backlog", completed, NREF + BMAX);
    check(!ref_urgent && !ref_req, "R11 backlog empty", {ref_urgent, ref_req}, 0);
    // steady rate with grant always given
    expect_refs(20);
    wait_until(t0 + 32 * IVL + 270);
    check(completed == NREF + BMAX + 20, "R9 average rate", completed, NREF + BMAX + 20);
    check(q.size() == 0, "R9 scoreboard drained", q.size(), 0);
    check(!we_bad, "R7 write enable high", we_bad, 0);
    check(!own_bad, "R8 strobes only while owned", own_bad, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule